// File: doc/BRIEF.md
# DDR2 Command Scheduler with Four-Activate Window Limit

This block decides, every clock cycle, which single command a DDR2 memory controller sends next. Five classes of work compete: refresh, column access (CAS), scrub, read and write. The block picks the most urgent class that is allowed to go. It asserts one bit of a grant vector and names the bank that is involved. The arbitration is combinational from the current requests and internal state. All internal state changes on the rising clock edge.

Two interval timers raise refresh and scrub work by themselves. Each timer is loaded from a configuration input that the system sets during boot and then holds constant. Writes are posted into one slot per bank, and the eight bank slots are built from identical logic. A read whose full address matches any posted write is held back until that write has drained. Scrub, read and write each open a row, so each counts as an ACTIVATE. A rolling history of recent activates stops any of these three classes once the window budget is used up.

Top module: `memsched_core`

## Requirements
- R1: At most one bit of `cmd_gnt` is set in any cycle. The bit positions are: bit 0 refresh, bit 1 CAS, bit 2 scrub, bit 3 read, bit 4 write. `cmd_gnt` is zero when no class is eligible, including the first cycle after reset when no request is present.
- R2: Among eligible classes the grant follows a fixed order: refresh, then CAS, then scrub, then read, then write.
- R3: The refresh counter is 13 bits wide. It is loaded with `cfg_ref_interval` during reset and again on every refresh grant. It decrements by one each cycle and holds at zero. Refresh is eligible while the counter is zero. The first refresh is therefore eligible in cycle I after reset, counting the first cycle after reset as cycle 0. After a refresh grant in cycle g, the next refresh is eligible in cycle g+I+1.
- R4: Scrub uses the same counting rule as R3, with a 12-bit counter loaded from `cfg_scrub_interval`.
- R5: A read is not granted while `rd_addr` equals, on all 32 bits, the address held in any occupied write slot. The read becomes eligible in the cycle after that write is granted.
- R6: Scrub, read and write grants each count as one ACTIVATE. In any FAW_CYCLES consecutive cycles (default 20), at most MAX_ACT ACTIVATEs (default 4) are granted. While the budget is spent, these three classes are not granted.
- R7: A pulse on `wr_push` stores `wr_addr` into the slot selected by `wr_bank`. A write grant serves the lowest-numbered occupied slot and frees it. A push into a slot that is occupied, and is not being freed in that same cycle, is ignored.
- R8: `cmd_bank` equals `rd_bank` on a read grant and the served slot number on a write grant. It is zero otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_ref_interval | input | 13 | Refresh interval, held constant after boot |
| cfg_scrub_interval | input | 12 | Scrub interval, held constant after boot |
| cas_req | input | 1 | Column access pending, held until granted |
| rd_valid | input | 1 | Read request pending |
| rd_bank | input | 3 | Bank of the pending read |
| rd_addr | input | 32 | Address of the pending read |
| wr_push | input | 1 | Post one write this cycle |
| wr_bank | input | 3 | Slot for the posted write |
| wr_addr | input | 32 | Address of the posted write |
| cmd_gnt | output | 5 | One-hot command grant |
| cmd_bank | output | 3 | Bank of a read or write grant |

## Verification
The bound checker watches, every cycle, that the grant is one-hot or zero and that a due refresh or a pending CAS wins as the order demands. It also checks that a read never issues against a matching posted write, that a granted refresh or scrub is not due again in the next cycle, that a drained slot is empty afterwards, and that no window of FAW_CYCLES holds more than the activate budget. The exact cycle on which each timer fires is shown only by the bench. The same holds for a fifth activate resuming when the oldest one leaves the window, for an ignored push into a busy slot, and for the bank reported on each grant. The bench shows these with a cycle-accurate model under directed and random traffic.

// File: rtl/memsched_pkg.sv
package memsched_pkg;
   localparam int NUM_CMD = 5;
   localparam int CMD_REF   = 0;
   localparam int CMD_CAS   = 1;
   localparam int CMD_SCRUB = 2;
   localparam int CMD_RD    = 3;
   localparam int CMD_WR    = 4;
   typedef logic [NUM_CMD-1:0] cmd_vec_t;
endpackage

// File: rtl/memsched_interval_timer.sv
module memsched_interval_timer #(
   parameter int CNT_W = 13
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] interval,
   input  logic             served,
   output logic             due
);
   logic [CNT_W-1:0] cnt_q;

   assign due = (cnt_q == '0);

   always_ff @(posedge clk) begin
      if (!rst_n || served) cnt_q <= interval;
      else if (!due)        cnt_q <= cnt_q - 1'b1;
   end
endmodule

// File: rtl/memsched_faw_limiter.sv
module memsched_faw_limiter #(
   parameter int FAW_CYCLES = 20,
   parameter int MAX_ACT    = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic act_now,
   output logic act_ok
);
   localparam int HIST_W = FAW_CYCLES - 1;
   localparam int CNT_W  = $clog2(FAW_CYCLES + 1);

   logic [HIST_W-1:0] hist_q;   // bit 0 = activate in the previous cycle
   logic [CNT_W-1:0]  win_cnt;

   always_comb begin
      win_cnt = '0;
      for (int i = 0; i < HIST_W; i++) win_cnt = win_cnt + CNT_W'(hist_q[i]);
   end

   assign act_ok = (int'(win_cnt) < MAX_ACT);

   if (HIST_W == 1) begin : g_short
      always_ff @(posedge clk) begin
         if (!rst_n) hist_q <= '0;
         else        hist_q <= act_now;
      end
   end else begin : g_shift
      always_ff @(posedge clk) begin
         if (!rst_n) hist_q <= '0;
         else        hist_q <= {hist_q[HIST_W-2:0], act_now};
      end
   end
endmodule

// File: rtl/memsched_wr_slot.sv
module memsched_wr_slot #(
   parameter int ADDR_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push,
   input  logic [ADDR_W-1:0] push_addr,
   input  logic              clear,
   input  logic [ADDR_W-1:0] probe_addr,
   output logic              valid,
   output logic              hit
);
   logic [ADDR_W-1:0] addr_q;

   assign hit = valid && (addr_q == probe_addr);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid  <= 1'b0;
         addr_q <= '0;
      end else begin
         if (clear) valid <= 1'b0;
         if (push && (!valid || clear)) begin
            valid  <= 1'b1;
            addr_q <= push_addr;
         end
      end
   end
endmodule

// File: rtl/memsched_core.sv
module memsched_core
   import memsched_pkg::*;
#(
   parameter int NUM_BANKS  = 8,
   parameter int ADDR_W     = 32,
   parameter int REF_W      = 13,
   parameter int SCRUB_W    = 12,
   parameter int FAW_CYCLES = 20,
   parameter int MAX_ACT    = 4,
   localparam int BANK_W    = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [REF_W-1:0]   cfg_ref_interval,
   input  logic [SCRUB_W-1:0] cfg_scrub_interval,
   input  logic               cas_req,
   input  logic               rd_valid,
   input  logic [BANK_W-1:0]  rd_bank,
   input  logic [ADDR_W-1:0]  rd_addr,
   input  logic               wr_push,
   input  logic [BANK_W-1:0]  wr_bank,
   input  logic [ADDR_W-1:0]  wr_addr,
   output logic [NUM_CMD-1:0] cmd_gnt,
   output logic [BANK_W-1:0]  cmd_bank
);
   if (NUM_BANKS < 2)              begin : g_bad_banks $error("NUM_BANKS must be at least 2"); end
   if (FAW_CYCLES < 2)             begin : g_bad_faw   $error("FAW_CYCLES must be at least 2"); end
   if (MAX_ACT < 1)                begin : g_bad_act   $error("MAX_ACT must be at least 1"); end
   if (REF_W < 2 || SCRUB_W < 2)   begin : g_bad_cnt   $error("timer widths must be at least 2"); end

   logic                 ref_due, scr_due, act_ok, act_now;
   logic [NUM_BANKS-1:0] slot_v, slot_hit;
   logic                 wr_any, rd_hazard;
   logic [BANK_W-1:0]    wr_sel;
   cmd_vec_t             elig, gnt;

   memsched_interval_timer #(.CNT_W(REF_W)) u_ref_tmr (
      .clk(clk), .rst_n(rst_n), .interval(cfg_ref_interval),
      .served(gnt[CMD_REF]), .due(ref_due));

   memsched_interval_timer #(.CNT_W(SCRUB_W)) u_scr_tmr (
      .clk(clk), .rst_n(rst_n), .interval(cfg_scrub_interval),
      .served(gnt[CMD_SCRUB]), .due(scr_due));

   assign act_now = gnt[CMD_SCRUB] | gnt[CMD_RD] | gnt[CMD_WR];

   memsched_faw_limiter #(.FAW_CYCLES(FAW_CYCLES), .MAX_ACT(MAX_ACT)) u_faw (
      .clk(clk), .rst_n(rst_n), .act_now(act_now), .act_ok(act_ok));

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      memsched_wr_slot #(.ADDR_W(ADDR_W)) u_slot (
         .clk        (clk),
         .rst_n      (rst_n),
         .push       (wr_push && (wr_bank == BANK_W'(b))),
         .push_addr  (wr_addr),
         .clear      (gnt[CMD_WR] && (wr_sel == BANK_W'(b))),
         .probe_addr (rd_addr),
         .valid      (slot_v[b]),
         .hit        (slot_hit[b]));
   end

   always_comb begin
      wr_any = |slot_v;
      wr_sel = '0;
      for (int i = NUM_BANKS - 1; i >= 0; i--)
         if (slot_v[i]) wr_sel = BANK_W'(i);
   end

   assign rd_hazard = |slot_hit;

   always_comb begin
      elig            = '0;
      elig[CMD_REF]   = ref_due;
      elig[CMD_CAS]   = cas_req;
      elig[CMD_SCRUB] = scr_due && act_ok;
      elig[CMD_RD]    = rd_valid && !rd_hazard && act_ok;
      elig[CMD_WR]    = wr_any && act_ok;
      gnt = '0;
      for (int i = NUM_CMD - 1; i >= 0; i--)
         if (elig[i]) gnt = cmd_vec_t'(1) << i;
   end

   assign cmd_gnt  = gnt;
   assign cmd_bank = gnt[CMD_RD] ? rd_bank : (gnt[CMD_WR] ? wr_sel : '0);
endmodule

// File: rtl/memsched_core_chk.sv
module memsched_core_chk
   import memsched_pkg::*;
#(
   parameter int NUM_BANKS  = 8,
   parameter int REF_W      = 13,
   parameter int SCRUB_W    = 12,
   parameter int FAW_CYCLES = 20,
   parameter int MAX_ACT    = 4,
   localparam int BANK_W    = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic [REF_W-1:0]     cfg_ref_interval,
   input logic [SCRUB_W-1:0]   cfg_scrub_interval,
   input logic                 cas_req,
   input logic                 rd_valid,
   input logic [BANK_W-1:0]    rd_bank,
   input logic                 wr_push,
   input logic [BANK_W-1:0]    wr_bank,
   input logic [NUM_CMD-1:0]   cmd_gnt,
   input logic [BANK_W-1:0]    cmd_bank,
   input logic                 ref_due,
   input logic                 scr_due,
   input logic [NUM_BANKS-1:0] slot_v,
   input logic [NUM_BANKS-1:0] slot_hit
);
   localparam int HIST_W = FAW_CYCLES - 1;
   logic [HIST_W-1:0] act_hist;
   logic              act;
   int                seen;

   assign act = cmd_gnt[CMD_SCRUB] | cmd_gnt[CMD_RD] | cmd_gnt[CMD_WR];

   always_ff @(posedge clk) begin
      if (!rst_n) act_hist <= '0;
      else        act_hist <= (act_hist << 1) | HIST_W'(act);
   end

   always_comb begin
      seen = 0;
      for (int i = 0; i < HIST_W; i++) seen = seen + int'(act_hist[i]);
   end

   p_onehot_gnt_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(cmd_gnt));

   p_ref_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ref_due |-> cmd_gnt[CMD_REF]);

   p_cas_second_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (cas_req && !ref_due) |-> cmd_gnt[CMD_CAS]);

   p_ref_reload_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_gnt[CMD_REF] && cfg_ref_interval != '0) |=> !ref_due);

   p_scr_reload_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_gnt[CMD_SCRUB] && cfg_scrub_interval != '0) |=> !scr_due);

   p_raw_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_valid && (|slot_hit)) |-> !cmd_gnt[CMD_RD]);

   p_faw_budget_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (seen + int'(act)) <= MAX_ACT);

   p_slot_free_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_gnt[CMD_WR] && !(wr_push && wr_bank == cmd_bank)) |=> !slot_v[$past(cmd_bank)]);

   p_rd_bank_r8: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_gnt[CMD_RD] |-> (cmd_bank == rd_bank));
endmodule

bind memsched_core memsched_core_chk #(
   .NUM_BANKS(NUM_BANKS), .REF_W(REF_W), .SCRUB_W(SCRUB_W),
   .FAW_CYCLES(FAW_CYCLES), .MAX_ACT(MAX_ACT)
) u_chk (
   .clk(clk), .rst_n(rst_n),
   .cfg_ref_interval(cfg_ref_interval), .cfg_scrub_interval(cfg_scrub_interval),
   .cas_req(cas_req), .rd_valid(rd_valid), .rd_bank(rd_bank),
   .wr_push(wr_push), .wr_bank(wr_bank),
   .cmd_gnt(cmd_gnt), .cmd_bank(cmd_bank),
   .ref_due(ref_due), .scr_due(scr_due),
   .slot_v(slot_v), .slot_hit(slot_hit));

// File: tb/sim_memsched_core.sv
`timescale 1ns/1ps
module sim_memsched_core;
   localparam int NB  = 8;
   localparam int FAW = 20;
   localparam int MAXA = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [12:0] cfg_ref_interval = '0;
   logic [11:0] cfg_scrub_interval = '0;
   logic        cas_req = 1'b0, rd_valid = 1'b0, wr_push = 1'b0;
   logic [2:0]  rd_bank = '0, wr_bank = '0;
   logic [31:0] rd_addr = '0, wr_addr = '0;
   logic [4:0]  cmd_gnt;
   logic [2:0]  cmd_bank;

   int checks = 0, failures = 0;
   bit done = 0;

   // model state
   int          m_ref, m_scr, m_ref_int, m_scr_int;
   bit          m_v [NB];
   logic [31:0] m_a [NB];
   bit          m_h [FAW-1];
   logic [4:0]  last_gnt;
   logic [2:0]  last_bank;

   memsched_core #(.NUM_BANKS(NB), .FAW_CYCLES(FAW), .MAX_ACT(MAXA)) u0 (
      .clk(clk), .rst_n(rst_n),
      .cfg_ref_interval(cfg_ref_interval), .cfg_scrub_interval(cfg_scrub_interval),
      .cas_req(cas_req), .rd_valid(rd_valid), .rd_bank(rd_bank), .rd_addr(rd_addr),
      .wr_push(wr_push), .wr_bank(wr_bank), .wr_addr(wr_addr),
      .cmd_gnt(cmd_gnt), .cmd_bank(cmd_bank));

   always #10 clk = ~clk;

   task automatic chk(bit ok, string req, int act, int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   task automatic idle_inputs();
      cas_req = 0; rd_valid = 0; wr_push = 0;
   endtask

   task automatic do_reset(int ri, int si);
      rst_n = 0;
      cfg_ref_interval = 13'(ri);
      cfg_scrub_interval = 12'(si);
      idle_inputs();
      repeat (3) @(negedge clk);
      m_ref_int = ri; m_scr_int = si; m_ref = ri; m_scr = si;
      for (int b = 0; b < NB; b++) begin m_v[b] = 0; m_a[b] = '0; end
      for (int i = 0; i < FAW-1; i++) m_h[i] = 0;
      rst_n = 1;
   endtask

   // compare the current cycle with the model, then advance the model and the clock
   task automatic step();
      bit hit, wany, aok;
      int wsel, acts;
      logic [4:0] eg;
      logic [2:0] eb;
      string req;
      #1;
      hit = 0; wany = 0; wsel = 0; acts = 0;
      for (int b = NB-1; b >= 0; b--) begin
         if (m_v[b] && m_a[b] == rd_addr) hit = 1;
         if (m_v[b]) begin wany = 1; wsel = b; end
      end
      for (int i = 0; i < FAW-1; i++) acts += m_h[i];
      aok = acts < MAXA;
      eg = '0; eb = '0;
      if (m_ref == 0)                   eg[0] = 1;
      else if (cas_req)                 eg[1] = 1;
      else if (m_scr == 0 && aok)       eg[2] = 1;
      else if (rd_valid && !hit && aok) begin eg[3] = 1; eb = rd_bank; end
      else if (wany && aok)             begin eg[4] = 1; eb = 3'(wsel); end
      if (cmd_gnt !== eg) begin
         if ($countones(cmd_gnt) > 1)       req = "R1";
         else if (eg[0] || cmd_gnt[0])      req = "R3";
         else if (eg[2] || cmd_gnt[2])      req = "R4";
         else if (rd_valid && hit)          req = "R5";
         else if (!aok)                     req = "R6";
         else if (eg[4] || cmd_gnt[4])      req = "R7";
         else                               req = "R2";
         chk(0, req, int'(cmd_gnt), int'(eg));
      end else begin
         chk(cmd_bank === eb, "R8", int'(cmd_bank), int'(eb));
      end
      last_gnt = cmd_gnt; last_bank = cmd_bank;
      // model advance
      if (eg[0]) m_ref = m_ref_int; else if (m_ref > 0) m_ref--;
      if (eg[2]) m_scr = m_scr_int; else if (m_scr > 0) m_scr--;
      if (eg[4]) m_v[wsel] = 0;
      if (wr_push && (!m_v[wr_bank] || (eg[4] && wsel == int'(wr_bank)))) begin
         m_v[wr_bank] = 1; m_a[wr_bank] = wr_addr;
      end
      for (int i = FAW-2; i > 0; i--) m_h[i] = m_h[i-1];
      m_h[0] = eg[2] | eg[3] | eg[4];
      @(negedge clk);
   endtask

   initial begin
      #(20 * 150000);
      if (!done) begin
         failures++; checks++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      int first_ref, first_scr, second_ref, nrd;
      void'($urandom(32'd2468));
      @(negedge clk);

      // timers from reset, idle otherwise
      do_reset(30, 45);
      first_ref = -1; first_scr = -1; second_ref = -1;
      for (int c = 0; c < 70; c++) begin
         step();
         if (c == 0) chk(last_gnt == 5'd0, "R1", int'(last_gnt), 0);
         if (last_gnt[0]) begin
            if (first_ref < 0) first_ref = c; else if (second_ref < 0) second_ref = c;
         end
         if (last_gnt[2] && first_scr < 0) first_scr = c;
      end
      chk(first_ref == 30, "R3", first_ref, 30);
      chk(second_ref == 61, "R3", second_ref, 61);
      chk(first_scr == 45, "R4", first_scr, 45);

      // activate window: back-to-back reads
      do_reset(8000, 4000);
      rd_valid = 1; rd_addr = 32'h1000_0000; rd_bank = 3'd5;
      nrd = 0;
      for (int c = 0; c <= FAW; c++) begin
         step();
         if (c < FAW && last_gnt[3]) nrd++;
         if (c == FAW) begin
            chk(last_gnt == 5'b01000, "R6", int'(last_gnt), 8);
            chk(last_bank == 3'd5, "R8", int'(last_bank), 5);
         end
      end
      chk(nrd == MAXA, "R6", nrd, MAXA);
      rd_valid = 0;
      repeat (FAW) step();

      // read-after-write hold, busy-slot push ignored
      cas_req = 1; wr_push = 1; wr_bank = 3'd3; wr_addr = 32'h2000_0040;
      step(); chk(last_gnt == 5'b00010, "R2", int'(last_gnt), 2);
      wr_addr = 32'h2000_0080;
      step();
      cas_req = 0; wr_push = 0; rd_valid = 1; rd_bank = 3'd1; rd_addr = 32'h2000_0080;
      step(); chk(last_gnt == 5'b01000, "R7", int'(last_gnt), 8);
      rd_addr = 32'h2000_0040;
      step();
      chk(last_gnt == 5'b10000, "R5", int'(last_gnt), 16);
      chk(last_bank == 3'd3, "R8", int'(last_bank), 3);
      step(); chk(last_gnt == 5'b01000, "R5", int'(last_gnt), 8);
      rd_valid = 0;
      step();

      // random traffic against the model
      do_reset(40, 27);
      for (int c = 0; c < 3000; c++) begin
         cas_req  = ($urandom_range(0, 3) == 0);
         rd_valid = ($urandom_range(0, 1) == 1);
         rd_bank  = 3'($urandom_range(0, 7));
         rd_addr  = 32'hC000_0000 | (32'($urandom_range(0, 7)) << 2);
         wr_push  = ($urandom_range(0, 2) == 0);
         wr_bank  = 3'($urandom_range(0, 7));
         wr_addr  = 32'hC000_0000 | (32'($urandom_range(0, 7)) << 2);
         step();
      end
      idle_inputs();

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule